// File: doc/BRIEF.md
# Iterative Integer Divider with Interrupt Abort

This block divides a 32-bit dividend by a 32-bit divisor for a processor execute stage. It handles both two's-complement and unsigned operands, and it produces the quotient and the remainder together. A one-cycle `start` pulse accepts the operands while the unit is idle. The unit then runs a radix-4 restoring loop, which retires two quotient bits per cycle. It pads to a fixed latency, so the result always appears the same number of cycles after the start, whatever the operand values.

The execute stage cannot be held for the full division when an interrupt is waiting. For that case, `irq_pending` cancels the operation in flight at the next clock edge. The unit then returns to idle, pulses `aborted` for one cycle and leaves the result registers untouched. Division by zero is not an error here; it has a defined result and the normal latency. Register-file writeback, hazard handling and interrupt arbitration are outside this block.

Top module: `div_iter_unit`

## Requirements
- R1: With `is_signed`=0, operands are unsigned and `quotient`/`remainder` equal floor(dividend/divisor) and dividend mod divisor.
- R2: With `is_signed`=1, operands are two's complement; the quotient is truncated toward zero and a nonzero remainder carries the sign of the dividend.
- R3: `done` is high for exactly one cycle per completed operation, and both results change only on that cycle, then hold until the next completion.
- R4: `done` rises exactly LATENCY (default 19) clock edges after the edge that accepts `start`, independent of operand values.
- R5: `busy` is high from the cycle after an accepted start until the cycle `done` or `aborted` rises; a `start` while `busy` is ignored and does not alter the operation in flight.
- R6: If `irq_pending` is high during a busy cycle, at the next edge `busy` falls, `aborted` pulses for one cycle, `done` does not rise, and `quotient`/`remainder` keep their previous values.
- R7: A divisor of zero yields a quotient of all ones and a remainder equal to the dividend, in both modes, with the normal latency.
- R8: In signed mode, 0x80000000 divided by 0xFFFFFFFF (-1) yields quotient 0x80000000 and remainder 0.
- R9: After reset, `busy`, `done` and `aborted` are low and `quotient`/`remainder` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a division; accepted only when idle |
| is_signed | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| dividend | input | 32 | Dividend, sampled with an accepted start |
| divisor | input | 32 | Divisor, sampled with an accepted start |
| irq_pending | input | 1 | Cancels the operation in flight |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| aborted | output | 1 | One-cycle cancellation pulse |
| quotient | output | 32 | Quotient from the last completed operation |
| remainder | output | 32 | Remainder from the last completed operation |

## Verification
The hardest situation to reach from the ports is a cancellation that happens mid-iteration, with a previous result still sitting in the output registers. Only that combination shows whether the partial state reaches the result. The bench first completes a known division, then starts one with different operands and raises `irq_pending` several cycles into the loop. It checks the abort pulse, checks that the old quotient and remainder are still present, and confirms that `done` stays low for longer than a full latency. A second start issued while busy, with different operands, shows that the result and the latency still belong to the first request.

// File: rtl/div_iter_pkg.sv
package div_iter_pkg;
  // Sign/exception information captured at operand acceptance
  typedef struct packed {
    logic neg_quo;   // quotient must be negated at the end
    logic neg_rem;   // remainder must be negated at the end
    logic by_zero;   // divisor was zero
  } div_flags_t;
endpackage

// File: rtl/div_operand_prep.sv
module div_operand_prep
  import div_iter_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] num_in,
  input  logic [WIDTH-1:0] den_in,
  input  logic             signed_mode,
  output logic [WIDTH-1:0] num_mag,
  output logic [WIDTH-1:0] den_mag,
  output div_flags_t       flags
);
  logic num_neg;
  logic den_neg;

  assign num_neg = signed_mode & num_in[WIDTH-1];
  assign den_neg = signed_mode & den_in[WIDTH-1];
  assign num_mag = num_neg ? (~num_in + 1'b1) : num_in;
  assign den_mag = den_neg ? (~den_in + 1'b1) : den_in;

  always_comb begin
    flags.neg_quo = num_neg ^ den_neg;
    flags.neg_rem = num_neg;
    flags.by_zero = (den_in == '0);
  end
endmodule

// File: rtl/div_radix_step.sv
module div_radix_step #(
  parameter int WIDTH      = 32,
  parameter int RADIX_BITS = 2
) (
  input  logic [WIDTH:0]   part_in,
  input  logic [WIDTH-1:0] shq_in,
  input  logic [WIDTH-1:0] den,
  output logic [WIDTH:0]   part_out,
  output logic [WIDTH-1:0] shq_out
);
  logic [WIDTH:0]   part_ch [RADIX_BITS+1];
  logic [WIDTH-1:0] shq_ch  [RADIX_BITS+1];

  assign part_ch[0] = part_in;
  assign shq_ch[0]  = shq_in;

  // One restoring stage per retired quotient bit
  for (genvar s = 0; s < RADIX_BITS; s++) begin : g_stage
    logic [WIDTH:0] trial;
    logic           fits;
    assign trial = {part_ch[s][WIDTH-1:0], shq_ch[s][WIDTH-1]};
    assign fits  = (trial >= {1'b0, den});
    assign part_ch[s+1] = fits ? (trial - {1'b0, den}) : trial;
    assign shq_ch[s+1]  = {shq_ch[s][WIDTH-2:0], fits};
  end

  assign part_out = part_ch[RADIX_BITS];
  assign shq_out  = shq_ch[RADIX_BITS];
endmodule

// File: rtl/div_result_fix.sv
module div_result_fix
  import div_iter_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] quo_mag,
  input  logic [WIDTH-1:0] rem_mag,
  input  logic [WIDTH-1:0] num_raw,
  input  div_flags_t       flags,
  output logic [WIDTH-1:0] quo_out,
  output logic [WIDTH-1:0] rem_out
);
  always_comb begin
    if (flags.by_zero) begin
      quo_out = '1;
      rem_out = num_raw;
    end else begin
      quo_out = flags.neg_quo ? (~quo_mag + 1'b1) : quo_mag;
      rem_out = flags.neg_rem ? (~rem_mag + 1'b1) : rem_mag;
    end
  end
endmodule

// File: rtl/div_iter_unit.sv
module div_iter_unit
  import div_iter_pkg::*;
#(
  parameter int WIDTH      = 32,
  parameter int LATENCY    = 19,
  parameter int RADIX_BITS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             is_signed,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  input  logic             irq_pending,
  output logic             busy,
  output logic             done,
  output logic             aborted,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder
);
  localparam int ITERS = WIDTH / RADIX_BITS;
  localparam int CW    = $clog2(LATENCY + 1);
  localparam logic [CW-1:0] LAST_CNT = CW'(LATENCY - 1);
  localparam logic [CW-1:0] ITER_CNT = CW'(ITERS);

  logic             busy_q, done_q, aborted_q;
  logic [CW-1:0]    cnt_q;
  logic [WIDTH:0]   part_q;
  logic [WIDTH-1:0] shq_q, den_q, num_raw_q, quo_q, rem_q;
  div_flags_t       flags_q;

  logic [WIDTH-1:0] num_mag, den_mag;
  div_flags_t       flags_in;
  logic [WIDTH:0]   part_nxt;
  logic [WIDTH-1:0] shq_nxt, quo_fix, rem_fix;

  div_operand_prep #(.WIDTH(WIDTH)) prep_i (
    .num_in(dividend), .den_in(divisor), .signed_mode(is_signed),
    .num_mag(num_mag), .den_mag(den_mag), .flags(flags_in)
  );

  div_radix_step #(.WIDTH(WIDTH), .RADIX_BITS(RADIX_BITS)) step_i (
    .part_in(part_q), .shq_in(shq_q), .den(den_q),
    .part_out(part_nxt), .shq_out(shq_nxt)
  );

  div_result_fix #(.WIDTH(WIDTH)) fix_i (
    .quo_mag(shq_q), .rem_mag(part_q[WIDTH-1:0]), .num_raw(num_raw_q),
    .flags(flags_q), .quo_out(quo_fix), .rem_out(rem_fix)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      aborted_q <= 1'b0;
      cnt_q     <= '0;
      part_q    <= '0;
      shq_q     <= '0;
      den_q     <= '0;
      num_raw_q <= '0;
      flags_q   <= '0;
      quo_q     <= '0;
      rem_q     <= '0;
    end else begin
      done_q    <= 1'b0;
      aborted_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          busy_q    <= 1'b1;
          cnt_q     <= '0;
          part_q    <= '0;
          shq_q     <= num_mag;
          den_q     <= den_mag;
          num_raw_q <= dividend;
          flags_q   <= flags_in;
        end
      end else if (irq_pending) begin
        busy_q    <= 1'b0;
        aborted_q <= 1'b1;
      end else if (cnt_q == LAST_CNT) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        quo_q  <= quo_fix;
        rem_q  <= rem_fix;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q < ITER_CNT) begin
          part_q <= part_nxt;
          shq_q  <= shq_nxt;
        end
      end
    end
  end

  assign busy      = busy_q;
  assign done      = done_q;
  assign aborted   = aborted_q;
  assign quotient  = quo_q;
  assign remainder = rem_q;
endmodule

// File: rtl/div_iter_chk.sv
module div_iter_chk #(
  parameter int WIDTH   = 32,
  parameter int LATENCY = 19
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             irq_pending,
  input logic             busy,
  input logic             done,
  input logic             aborted,
  input logic [WIDTH-1:0] quotient,
  input logic [WIDTH-1:0] remainder
);
  localparam int LW = $clog2(LATENCY + 2);
  logic [LW-1:0] lat_cnt;

  always_ff @(posedge clk) begin
    if (rst) lat_cnt <= '0;
    else if (start && !busy) lat_cnt <= '0;
    else if (busy) lat_cnt <= lat_cnt + 1'b1;
  end

  // R5
  accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R3
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(quotient) && $stable(remainder)));
  // R4
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R4
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (lat_cnt == LW'(LATENCY)));
  // R6
  abort_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && irq_pending) |=> (aborted && !busy && !done));
  // R6
  abort_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    aborted |=> !aborted);
  // R6
  abort_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(aborted && done));
endmodule

bind div_iter_unit div_iter_chk #(.WIDTH(WIDTH), .LATENCY(LATENCY)) chk_i (
  .clk(clk), .rst(rst), .start(start), .irq_pending(irq_pending),
  .busy(busy), .done(done), .aborted(aborted),
  .quotient(quotient), .remainder(remainder)
);

// File: tb/div_iter_unit_tb_top.sv
module div_iter_unit_tb_top;
  localparam int W   = 32;
  localparam int LAT = 19;

  logic clk = 1'b0;
  logic rst, start, is_signed, irq_pending;
  logic [W-1:0] dividend, divisor;
  logic busy, done, aborted;
  logic [W-1:0] quotient, remainder;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  div_iter_unit #(.WIDTH(W), .LATENCY(LAT), .RADIX_BITS(2)) dut_i (
    .clk(clk), .rst(rst), .start(start), .is_signed(is_signed),
    .dividend(dividend), .divisor(divisor), .irq_pending(irq_pending),
    .busy(busy), .done(done), .aborted(aborted),
    .quotient(quotient), .remainder(remainder)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference model written from the requirements
  task automatic ref_div(input logic [W-1:0] a, input logic [W-1:0] b, input logic sgn,
                         output logic [W-1:0] q, output logic [W-1:0] r);
    if (b == '0) begin
      q = '1; r = a;
    end else if (sgn) begin
      if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) begin
        q = 32'h8000_0000; r = '0;
      end else begin
        q = $signed(a) / $signed(b);
        r = $signed(a) % $signed(b);
      end
    end else begin
      q = a / b; r = a % b;
    end
  endtask

  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input logic sgn,
                        input string req);
    logic [W-1:0] eq, er;
    int lat;
    ref_div(a, b, sgn, eq, er);
    @(negedge clk);
    start = 1'b1; dividend = a; divisor = b; is_signed = sgn;
    @(negedge clk);
    start = 1'b0;
    chk("R5 busy after start", {31'd0, busy}, 32'd1);
    lat = 0;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    chk({req, " quotient"}, quotient, eq);
    chk({req, " remainder"}, remainder, er);
    chk("R4 latency", lat, LAT);
    chk("R5 busy low at done", {31'd0, busy}, 32'd0);
    @(negedge clk);
    chk("R3 done one cycle", {31'd0, done}, 32'd0);
    chk("R3 quotient held", quotient, eq);
  endtask

  task automatic t_reset;
    rst = 1'b1; start = 1'b0; is_signed = 1'b0; irq_pending = 1'b0;
    dividend = '0; divisor = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 busy", {31'd0, busy}, 32'd0);
    chk("R9 done", {31'd0, done}, 32'd0);
    chk("R9 aborted", {31'd0, aborted}, 32'd0);
    chk("R9 quotient", quotient, '0);
    chk("R9 remainder", remainder, '0);
  endtask

  task automatic t_unsigned;
    run_op(32'd100, 32'd7, 1'b0, "R1");
    run_op(32'hFFFF_FFFF, 32'd1, 1'b0, "R1");
    run_op(32'hFFFF_FFFF, 32'hFFFF_FFFE, 1'b0, "R1");
    run_op(32'h8000_0000, 32'd3, 1'b0, "R1");
    run_op(32'd5, 32'd9, 1'b0, "R1");
  endtask

  task automatic t_signed;
    run_op(-32'sd7, 32'sd2, 1'b1, "R2");
    run_op(32'sd7, -32'sd2, 1'b1, "R2");
    run_op(-32'sd7, -32'sd2, 1'b1, "R2");
    run_op(-32'sd1000003, 32'sd97, 1'b1, "R2");
    run_op(32'h8000_0000, 32'sd1, 1'b1, "R2");
  endtask

  task automatic t_div_zero;
    run_op(32'd1234, 32'd0, 1'b0, "R7");
    run_op(-32'sd55, 32'd0, 1'b1, "R7");
  endtask

  task automatic t_overflow;
    run_op(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, "R8");
  endtask

  task automatic t_busy_ignore;
    logic [W-1:0] eq, er;
    int lat;
    ref_div(32'd999, 32'd10, 1'b0, eq, er);
    @(negedge clk);
    start = 1'b1; dividend = 32'd999; divisor = 32'd10; is_signed = 1'b0;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    repeat (2) begin @(negedge clk); lat++; end
    start = 1'b1; dividend = 32'd50; divisor = 32'd3; is_signed = 1'b1;
    @(negedge clk); lat++;
    start = 1'b0;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    chk("R5 ignored start quotient", quotient, eq);
    chk("R5 ignored start remainder", remainder, er);
    chk("R5 ignored start latency", lat, LAT);
  endtask

  task automatic t_abort;
    logic [W-1:0] q0, r0;
    bit saw_done;
    q0 = quotient; r0 = remainder;
    @(negedge clk);
    start = 1'b1; dividend = 32'd77777; divisor = 32'd13; is_signed = 1'b0;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    irq_pending = 1'b1;
    @(negedge clk);
    irq_pending = 1'b0;
    chk("R6 aborted pulse", {31'd0, aborted}, 32'd1);
    chk("R6 busy cleared", {31'd0, busy}, 32'd0);
    chk("R6 no done", {31'd0, done}, 32'd0);
    @(negedge clk);
    chk("R6 aborted one cycle", {31'd0, aborted}, 32'd0);
    saw_done = 1'b0;
    repeat (LAT + 5) begin
      @(negedge clk);
      if (done) saw_done = 1'b1;
    end
    chk("R6 no later done", {31'd0, saw_done}, 32'd0);
    chk("R6 quotient kept", quotient, q0);
    chk("R6 remainder kept", remainder, r0);
    run_op(32'd77777, 32'd13, 1'b0, "R6 recovery");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset;
    t_unsigned;
    t_signed;
    t_div_zero;
    t_overflow;
    t_busy_ignore;
    t_abort;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule